// File: doc/BRIEF.md
# Scrolling Tile Layer Renderer

This block turns a raster position into the pixel stream of one tile layer. The map is 64 tiles wide and 28 tiles tall, and each tile is 8 by 8 pixels. On every pixel clock the block takes the horizontal and vertical raster counters and adds the scroll offsets, wrapping each sum to the size of the map. It reads the tile code and the attribute of the next tile from a tile RAM, then reads that tile's graphics row from a graphics ROM. It presents each pixel as a pixel value plus a colour-set index, and a palette stage further down the pipe uses the pair.

The parameter `BPP` selects one of two layer formats. With `BPP = 1` (the character layer) each graphics byte holds eight 1-bit pixels, the colour set has 6 bits, the layer scrolls only along the scan line, and a blank tile is transparent. With `BPP = 2` (the background layer) two bit-planes are read side by side as one 16-bit word, the colour set has 7 bits, and the layer scrolls in both directions.

Both memories are synchronous and sit outside the block. Each returns its data one clock after the address. The fetch for a tile is timed so that the tile takes over the moment the previous one ends.

Top module: `tilemap_layer`

## Requirements
- R1: While `rst_n` is low, `pix_set` and `pix_val` are 0.
- R2: The pixel shown two clocks after a set of counter inputs belongs to map column x = (hcnt + scroll_x) mod 512. Its graphics row is y[2:0]. Its bit is bit 7 − x[2:0] of the graphics byte, so the leftmost pixel is the MSB.
- R3: Horizontal scrolling wraps: map column 63 is followed by column 0.
- R4: With `BPP = 2`, y = (vcnt + scroll_y) mod 224, and the tile row is y[7:3]. Both inputs are below 224.
- R5: With `BPP = 1`, y = vcnt, and `scroll_y` has no effect on any output.
- R6: `tram_addr` = {row[4:0], column[5:0]} and `tram_data` = {attribute[15:8], code[7:0]}. `grom_addr` = {code, y[2:0]}. Each memory returns data one clock after the address.
- R7: With `BPP = 2`, pixel value bit 0 comes from plane byte `grom_data[7:0]` and bit 1 comes from `grom_data[15:8]`. Both bytes use the same bit index.
- R8: The colour set is attribute[5:0] for `BPP = 1` and attribute[6:0] for `BPP = 2`.
- R9: With `BPP = 1`, a tile whose code is 0 and whose colour set is 0 shows pixel value 0 and set 0, whatever its graphics are.
- R10: `tram_addr` always points at the column after the one the block is currently drawing. A tile's graphics are loaded only between the last pixel of the previous tile and its own first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcnt | input | 9 | Horizontal raster counter, +1 per clock within a line |
| vcnt | input | 8 | Vertical raster counter |
| scroll_x | input | 9 | Horizontal scroll offset |
| scroll_y | input | 8 | Vertical scroll offset (used only when BPP = 2) |
| tram_addr | output | 11 | Tile RAM read address {row, column} |
| tram_data | input | 16 | Tile RAM data {attribute, code} |
| grom_addr | output | 11 | Graphics ROM read address {code, fine row} |
| grom_data | input | 8·BPP | Graphics ROM data, one byte per bit-plane |
| pix_set | output | 6 (7 when BPP = 2) | Colour-set index |
| pix_val | output | BPP | Pixel value within the set |

## Verification
Some properties are checked on every clock. The tile RAM column always runs one tile ahead of the registered raster position. The row stays inside the 28-row map. The character layer's row follows `vcnt` alone. The tile buffer holds still except at a tile boundary. A blank character tile produces a zero pixel. Only the bench's scenarios show the pixel-exact result: they drive full scan lines over random map and graphics contents, and they force horizontal and vertical wrap-around and transparent tiles. That is the only way to show the right bit, plane and colour set reaching the outputs two clocks after the counters.

// File: rtl/tilemap_pkg.sv
package tilemap_pkg;
   // tiles are square, 8 pixels a side
   localparam int TILE_LG = 3;
   localparam int TILE_PX = 1 << TILE_LG;
   // attribute byte stored next to every tile code
   localparam int ATTR_W  = 8;

   // width of the colour-set field for a given pixel depth
   function automatic int set_width(input int bpp);
      return (bpp == 1) ? 6 : 7;
   endfunction
endpackage

// File: rtl/tilemap_scroll_stage.sv
// Registers the scrolled map position of the current raster pixel.
module tilemap_scroll_stage
   import tilemap_pkg::*;
#(
   parameter int XW      = 9,
   parameter int YW      = 8,
   parameter int ROWS_PX = 224,
   parameter int USE_SY  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] hcnt,
   input  logic [XW-1:0] scroll_x,
   input  logic [YW-1:0] vcnt,
   input  logic [YW-1:0] scroll_y,
   output logic [XW-1:0] x_q,
   output logic [YW-1:0] y_q
);
   logic [XW-1:0] x_d;
   logic [YW-1:0] y_d;

   // map width is a power of two: truncation is the wrap
   assign x_d = hcnt + scroll_x;

   generate
      if (USE_SY != 0) begin : g_vscroll
         logic [YW:0] y_sum;
         logic [YW:0] y_wrap;
         assign y_sum  = {1'b0, vcnt} + {1'b0, scroll_y};
         assign y_wrap = y_sum - (YW+1)'(ROWS_PX);
         assign y_d    = (y_sum >= (YW+1)'(ROWS_PX)) ? y_wrap[YW-1:0] : y_sum[YW-1:0];
      end else begin : g_hscroll_only
         logic sy_unused;
         assign sy_unused = ^scroll_y;
         assign y_d       = vcnt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         x_q <= x_d;
         y_q <= y_d;
      end
   end
endmodule

// File: rtl/tilemap_fetch.sv
// Look-ahead fetch of the next tile: tile RAM, then graphics ROM, then a
// staging buffer that is swapped into the live buffer at the tile boundary.
module tilemap_fetch
   import tilemap_pkg::*;
#(
   parameter  int BPP     = 1,
   parameter  int COL_LG  = 6,
   parameter  int ROW_W   = 5,
   parameter  int CODE_W  = 8,
   parameter  int YW      = 8,
   parameter  int SET_W   = 6,
   localparam int XW      = COL_LG + TILE_LG,
   localparam int TRAM_AW = ROW_W + COL_LG,
   localparam int TRAM_DW = CODE_W + ATTR_W,
   localparam int GROM_AW = CODE_W + TILE_LG,
   localparam int GROM_DW = BPP * TILE_PX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [XW-1:0]      x_q,
   input  logic [YW-1:0]      y_q,
   output logic [TRAM_AW-1:0] tram_addr,
   input  logic [TRAM_DW-1:0] tram_data,
   output logic [GROM_AW-1:0] grom_addr,
   input  logic [GROM_DW-1:0] grom_data,
   output logic [GROM_DW-1:0] cur_bits,
   output logic [SET_W-1:0]   cur_set,
   output logic               cur_clear
);
   // phase 4: tile RAM address used, phase 5: ROM address used,
   // phase 6: ROM data staged, phase 7 -> 0: staged tile goes live
   localparam logic [TILE_LG-1:0] PH_STAGE = TILE_LG'(TILE_PX - 2);
   localparam logic [TILE_LG-1:0] PH_SWAP  = TILE_LG'(TILE_PX - 1);

   logic [TILE_LG-1:0] phase;
   logic [COL_LG-1:0]  col_next;
   logic [ROW_W-1:0]   row;
   logic [CODE_W-1:0]  code;
   logic [ATTR_W-1:0]  attr;
   logic [SET_W-1:0]   tile_set;
   logic               clear_d;
   logic               attr_unused;

   logic [GROM_DW-1:0] nxt_bits;
   logic [SET_W-1:0]   nxt_set;
   logic               nxt_clear;

   assign phase     = x_q[TILE_LG-1:0];
   assign col_next  = x_q[XW-1:TILE_LG] + COL_LG'(1);
   assign row       = y_q[ROW_W+TILE_LG-1:TILE_LG];
   assign tram_addr = {row, col_next};

   assign code        = tram_data[CODE_W-1:0];
   assign attr        = tram_data[TRAM_DW-1:CODE_W];
   assign tile_set    = attr[SET_W-1:0];
   assign attr_unused = ^attr[ATTR_W-1:SET_W];
   assign grom_addr   = {code, y_q[TILE_LG-1:0]};

   generate
      if (BPP == 1) begin : g_transparent
         assign clear_d = (code == '0) && (tile_set == '0);
      end else begin : g_opaque
         assign clear_d = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_bits  <= '0;
         nxt_set   <= '0;
         nxt_clear <= 1'b0;
         cur_bits  <= '0;
         cur_set   <= '0;
         cur_clear <= 1'b0;
      end else begin
         if (phase == PH_STAGE) begin
            nxt_bits  <= grom_data;
            nxt_set   <= tile_set;
            nxt_clear <= clear_d;
         end
         if (phase == PH_SWAP) begin
            cur_bits  <= nxt_bits;
            cur_set   <= nxt_set;
            cur_clear <= nxt_clear;
         end
      end
   end
endmodule

// File: rtl/tilemap_pixel_out.sv
// Picks the pixel of the live tile by phase and registers the output pair.
module tilemap_pixel_out
   import tilemap_pkg::*;
#(
   parameter  int BPP     = 1,
   parameter  int SET_W   = 6,
   localparam int GROM_DW = BPP * TILE_PX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TILE_LG-1:0] phase,
   input  logic [GROM_DW-1:0] cur_bits,
   input  logic [SET_W-1:0]   cur_set,
   input  logic               cur_clear,
   output logic [SET_W-1:0]   pix_set,
   output logic [BPP-1:0]     pix_val
);
   logic [TILE_LG-1:0] bit_idx;
   logic [BPP-1:0]     val_d;

   // leftmost pixel lives in the MSB of each plane byte
   assign bit_idx = ~phase;

   generate
      for (genvar p = 0; p < BPP; p++) begin : g_plane
         logic [TILE_PX-1:0] plane;
         assign plane    = cur_bits[p*TILE_PX +: TILE_PX];
         assign val_d[p] = plane[bit_idx];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_set <= '0;
         pix_val <= '0;
      end else if (cur_clear) begin
         pix_set <= '0;
         pix_val <= '0;
      end else begin
         pix_set <= cur_set;
         pix_val <= val_d;
      end
   end
endmodule

// File: rtl/tilemap_layer.sv
// Scrolling tile layer: scroll stage -> look-ahead fetch -> pixel output.
module tilemap_layer
   import tilemap_pkg::*;
#(
   parameter  int BPP      = 1,
   parameter  int COL_LG   = 6,
   parameter  int MAP_ROWS = 28,
   parameter  int CODE_W   = 8,
   parameter  int YW       = 8,
   localparam int XW       = COL_LG + TILE_LG,
   localparam int ROW_W    = $clog2(MAP_ROWS),
   localparam int ROWS_PX  = MAP_ROWS * TILE_PX,
   localparam int TRAM_AW  = ROW_W + COL_LG,
   localparam int TRAM_DW  = CODE_W + ATTR_W,
   localparam int GROM_AW  = CODE_W + TILE_LG,
   localparam int GROM_DW  = BPP * TILE_PX,
   localparam int SET_W    = set_width(BPP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [XW-1:0]      hcnt,
   input  logic [YW-1:0]      vcnt,
   input  logic [XW-1:0]      scroll_x,
   input  logic [YW-1:0]      scroll_y,
   output logic [TRAM_AW-1:0] tram_addr,
   input  logic [TRAM_DW-1:0] tram_data,
   output logic [GROM_AW-1:0] grom_addr,
   input  logic [GROM_DW-1:0] grom_data,
   output logic [SET_W-1:0]   pix_set,
   output logic [BPP-1:0]     pix_val
);
   generate
      if (BPP != 1 && BPP != 2) begin : g_bad_bpp
         $error("tilemap_layer: BPP must be 1 or 2");
      end
      if (ROW_W + TILE_LG > YW) begin : g_bad_yw
         $error("tilemap_layer: YW too narrow for MAP_ROWS");
      end
      if (ROWS_PX >= (1 << YW)) begin : g_bad_rows
         $error("tilemap_layer: map height must fit below 2**YW");
      end
   endgenerate

   logic [XW-1:0]      x_q;
   logic [YW-1:0]      y_q;
   logic [GROM_DW-1:0] cur_bits;
   logic [SET_W-1:0]   cur_set;
   logic               cur_clear;

   tilemap_scroll_stage #(
      .XW      (XW),
      .YW      (YW),
      .ROWS_PX (ROWS_PX),
      .USE_SY  ((BPP == 2) ? 1 : 0)
   ) u_scroll (
      .clk      (clk),
      .rst_n    (rst_n),
      .hcnt     (hcnt),
      .scroll_x (scroll_x),
      .vcnt     (vcnt),
      .scroll_y (scroll_y),
      .x_q      (x_q),
      .y_q      (y_q)
   );

   tilemap_fetch #(
      .BPP    (BPP),
      .COL_LG (COL_LG),
      .ROW_W  (ROW_W),
      .CODE_W (CODE_W),
      .YW     (YW),
      .SET_W  (SET_W)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .x_q       (x_q),
      .y_q       (y_q),
      .tram_addr (tram_addr),
      .tram_data (tram_data),
      .grom_addr (grom_addr),
      .grom_data (grom_data),
      .cur_bits  (cur_bits),
      .cur_set   (cur_set),
      .cur_clear (cur_clear)
   );

   tilemap_pixel_out #(
      .BPP   (BPP),
      .SET_W (SET_W)
   ) u_pixel (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (x_q[TILE_LG-1:0]),
      .cur_bits  (cur_bits),
      .cur_set   (cur_set),
      .cur_clear (cur_clear),
      .pix_set   (pix_set),
      .pix_val   (pix_val)
   );
endmodule

// File: rtl/tilemap_layer_chk.sv
// Cycle-level properties of tilemap_layer, attached with bind below.
module tilemap_layer_chk
   import tilemap_pkg::*;
#(
   parameter int BPP      = 1,
   parameter int COL_LG   = 6,
   parameter int MAP_ROWS = 28,
   parameter int YW       = 8,
   parameter int XW       = 9,
   parameter int ROW_W    = 5,
   parameter int TRAM_AW  = 11,
   parameter int GROM_DW  = 8,
   parameter int SET_W    = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [XW-1:0]      hcnt,
   input logic [XW-1:0]      scroll_x,
   input logic [YW-1:0]      vcnt,
   input logic [YW-1:0]      scroll_y,
   input logic [XW-1:0]      x_q,
   input logic [TRAM_AW-1:0] tram_addr,
   input logic [GROM_DW-1:0] cur_bits,
   input logic               cur_clear,
   input logic [BPP-1:0]     pix_val,
   input logic [SET_W-1:0]   pix_set
);
   localparam int ROWS_PX = MAP_ROWS * TILE_PX;

   logic              armed;
   logic [XW-1:0]     x_prev;
   logic [YW-1:0]     v_prev;
   logic [YW-1:0]     sy_prev;
   logic [COL_LG-1:0] tram_col;
   logic [ROW_W-1:0]  tram_row;

   assign tram_col = tram_addr[COL_LG-1:0];
   assign tram_row = tram_addr[TRAM_AW-1:COL_LG];

   // armed: the previous edge loaded the scroll stage from live inputs
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
      x_prev  <= hcnt + scroll_x;
      v_prev  <= vcnt;
      sy_prev <= scroll_y;
   end

   // R4: the fetched row never leaves the map for legal inputs
   p_row_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && v_prev < YW'(ROWS_PX) && sy_prev < YW'(ROWS_PX))
         |-> (tram_row < ROW_W'(MAP_ROWS)));

   // R10: the tile RAM address runs one column ahead of the drawn pixel
   p_fetch_ahead_r10: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (tram_col == x_prev[XW-1:TILE_LG] + COL_LG'(1)));

   // R10: the live tile buffer changes only at a tile boundary
   p_tile_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (x_q[TILE_LG-1:0] != TILE_LG'(TILE_PX - 1)) |=> $stable(cur_bits));

   generate
      if (BPP == 1) begin : g_fg
         // R5: the character layer row follows vcnt alone
         p_row_no_sy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (tram_row == v_prev[ROW_W+TILE_LG-1:TILE_LG]));

         // R9: a blank tile emits a zero pixel and set
         p_transparent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            cur_clear |=> (pix_val == '0 && pix_set == '0));
      end
   endgenerate
endmodule

bind tilemap_layer tilemap_layer_chk #(
   .BPP      (BPP),
   .COL_LG   (COL_LG),
   .MAP_ROWS (MAP_ROWS),
   .YW       (YW),
   .XW       (XW),
   .ROW_W    (ROW_W),
   .TRAM_AW  (TRAM_AW),
   .GROM_DW  (GROM_DW),
   .SET_W    (SET_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hcnt      (hcnt),
   .scroll_x  (scroll_x),
   .vcnt      (vcnt),
   .scroll_y  (scroll_y),
   .x_q       (x_q),
   .tram_addr (tram_addr),
   .cur_bits  (cur_bits),
   .cur_clear (cur_clear),
   .pix_val   (pix_val),
   .pix_set   (pix_set)
);

// File: tb/tilemap_layer_tb_top.sv
`timescale 1ns/1ps
module tilemap_layer_tb_top;
   localparam int HTOT     = 384;
   localparam int CHK_FROM = 16;
   localparam int ROWS_PX  = 224;
   localparam int NLINES   = 40;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic [8:0] hcnt, sx;
   logic [7:0] vcnt, sy;

   logic [10:0] ta_f, ga_f, ta_b, ga_b;
   logic [15:0] td_f, td_b;
   logic [7:0]  gd_f;
   logic [15:0] gd_b;
   logic [5:0]  set_f;
   logic [0:0]  val_f;
   logic [6:0]  set_b;
   logic [1:0]  val_b;

   logic [15:0] tmem [2048];
   logic [7:0]  gfg  [2048];
   logic [15:0] gbg  [2048];

   tilemap_layer #(.BPP(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .scroll_x(sx), .scroll_y(sy),
      .tram_addr(ta_f), .tram_data(td_f), .grom_addr(ga_f), .grom_data(gd_f),
      .pix_set(set_f), .pix_val(val_f));

   tilemap_layer #(.BPP(2)) dut_bg_i (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .scroll_x(sx), .scroll_y(sy),
      .tram_addr(ta_b), .tram_data(td_b), .grom_addr(ga_b), .grom_data(gd_b),
      .pix_set(set_b), .pix_val(val_b));

   // synchronous memory models, one clock of read latency
   always @(posedge clk) begin
      td_f <= tmem[ta_f];
      td_b <= tmem[ta_b];
      gd_f <= gfg[ga_f];
      gd_b <= gbg[ga_b];
   end

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ypos(input bit bg, input int v, input int s);
      return bg ? (v + s) % ROWS_PX : v;
   endfunction

   function automatic int tidx(input bit bg, input int h, input int v,
                               input int xs, input int ys, input int dc);
      int x;
      int col;
      x   = (h + xs) % 512;
      col = ((x >> 3) + dc) % 64;
      return (ypos(bg, v, ys) >> 3) * 64 + col;
   endfunction

   task automatic check_pixel(input bit bg, input int h, input int v, input int xs,
                              input int ys, input int av, input int as);
      int x, y, w, code, attr, gi, b, ev, es;
      string tag;
      x    = (h + xs) % 512;
      y    = ypos(bg, v, ys);
      w    = int'(tmem[(y >> 3) * 64 + (x >> 3)]);
      code = w & 255;
      attr = (w >> 8) & 255;
      gi   = code * 8 + (y % 8);
      b    = 7 - (x % 8);
      if (!bg) begin
         if (code == 0 && (attr & 63) == 0) begin
            ev = 0; es = 0; tag = "R9";
         end else begin
            ev  = (int'(gfg[gi]) >> b) & 1;
            es  = attr & 63;
            tag = (ys != 0) ? "R5" : (((h + xs) >= 512) ? "R3" : "R2");
         end
      end else begin
         ev  = ((int'(gbg[gi]) >> b) & 1) | (((int'(gbg[gi]) >> (8 + b)) & 1) << 1);
         es  = attr & 127;
         tag = ((v + ys) >= ROWS_PX) ? "R4" : "R7";
      end
      chk(av == ev, tag, av, ev);
      chk(as == es, "R8", as, es);
   endtask

   // history: index 0 = previous cycle, index 1 = two cycles back
   int p_h[2], p_v[2], p_sx[2], p_sy[2];
   bit p_ok[2] = '{1'b0, 1'b0};

   always @(negedge clk) begin
      if (p_ok[1] && p_h[1] >= CHK_FROM) begin
         check_pixel(1'b0, p_h[1], p_v[1], p_sx[1], p_sy[1], int'(val_f), int'(set_f));
         check_pixel(1'b1, p_h[1], p_v[1], p_sx[1], p_sy[1], int'(val_b), int'(set_b));
      end
      if (p_ok[0]) begin
         // R10: next-column tile address from the previous cycle's position
         chk(int'(ta_f) == tidx(1'b0, p_h[0], p_v[0], p_sx[0], p_sy[0], 1), "R10",
             int'(ta_f), tidx(1'b0, p_h[0], p_v[0], p_sx[0], p_sy[0], 1));
         chk(int'(ta_b) == tidx(1'b1, p_h[0], p_v[0], p_sx[0], p_sy[0], 1), "R10",
             int'(ta_b), tidx(1'b1, p_h[0], p_v[0], p_sx[0], p_sy[0], 1));
      end
      if (p_ok[0] && p_ok[1] && p_h[0] != 0) begin
         int ef, eb;
         ef = (int'(tmem[tidx(1'b0, p_h[1], p_v[1], p_sx[1], p_sy[1], 1)]) & 255) * 8
              + (ypos(1'b0, p_v[0], p_sy[0]) % 8);
         eb = (int'(tmem[tidx(1'b1, p_h[1], p_v[1], p_sx[1], p_sy[1], 1)]) & 255) * 8
              + (ypos(1'b1, p_v[0], p_sy[0]) % 8);
         chk(int'(ga_f) == ef, "R6", int'(ga_f), ef);
         chk(int'(ga_b) == eb, "R6", int'(ga_b), eb);
      end
      p_h[1] = p_h[0];   p_v[1] = p_v[0];   p_sx[1] = p_sx[0];
      p_sy[1] = p_sy[0]; p_ok[1] = p_ok[0];
      p_h[0] = int'(hcnt); p_v[0] = int'(vcnt); p_sx[0] = int'(sx);
      p_sy[0] = int'(sy);  p_ok[0] = rst_n;
   end

   initial begin
      void'($urandom(32'd7301));
      for (int i = 0; i < 2048; i++) begin
         tmem[i] = 16'($urandom);
         if ($urandom % 6 == 0) tmem[i] = 16'h0000;
         else if ($urandom % 8 == 0) tmem[i][7:0] = 8'h00;
         gfg[i] = 8'($urandom);
         gbg[i] = 16'($urandom);
      end
      for (int i = 0; i < 8; i++) gfg[i] = 8'hA5;

      rst_n = 1'b0;
      hcnt = '0; vcnt = '0; sx = 9'd37; sy = 8'd11;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(set_f == '0 && val_f == '0, "R1", int'({set_f, val_f}), 0);
      chk(set_b == '0 && val_b == '0, "R1", int'({set_b, val_b}), 0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;

      for (int ln = 0; ln < NLINES; ln++) begin
         case (ln)
            0: begin sx = 9'd0;   sy = 8'd0;   vcnt = 8'd8;   end
            1: begin sx = 9'd505; sy = 8'd0;   vcnt = 8'd100; end
            2: begin sx = 9'd511; sy = 8'd223; vcnt = 8'd223; end
            3: begin sx = 9'd3;   sy = 8'd200; vcnt = 8'd150; end
            4: begin sx = 9'd0;   sy = 8'd0;   vcnt = 8'd223; end
            default: begin
               sx   = 9'($urandom % 512);
               sy   = 8'($urandom % ROWS_PX);
               vcnt = 8'($urandom % ROWS_PX);
            end
         endcase
         for (int h = 0; h < HTOT; h++) begin
            hcnt = 9'(h);
            @(posedge clk);
            #2;
         end
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, NLINES * HTOT);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule